// File: doc/BRIEF.md
# Two-Wire Bus Slave Holding a 10-bit Current-DAC Code

This block is the serial front end for a 10-bit current-output converter. A bus master reaches it through the common two-wire protocol (I2C). The block oversamples the clock line and the data line with a fast system clock. It finds start and stop conditions and decodes a 7-bit device address, of which the two lowest bits are don't-care. It acknowledges the address and every data byte. A write carries two bytes into a 16-bit holding word. Only after the second byte has arrived is that word moved into the converter register, which drives the code and power-down outputs. A read sends the holding word back, high byte first. A read that transfers both bytes leaves the holding word at zero.

The only data path is the bus itself, so the block has no valid/ready interface. Flow control belongs to the bus master. The slave never stretches the clock and never applies back-pressure. The master must allow an SCL low phase of at least several system clocks. The slave drives the data line only by asserting a pull-low enable, which the pad turns into an open-drain output.

Top module: `dacbus_slave_top`

## Requirements
- R1: After a synchronous reset, `dac_code` is 0, `pwr_down` is 0, `sda_pull` is 0, and the holding word is zero.
- R2: The device responds to a first byte whose upper five bits are 5'b00011. The two address bits below them are ignored, so the address bytes 0x18 to 0x1F (write and read at device addresses 0x0C to 0x0F) are acknowledged. Any other address gets no acknowledge, and the slave does not drive the line until the next start.
- R3: An SDA fall while SCL is high is a start, and an SDA rise while SCL is high is a stop. Neither is taken as data. A start always restarts address reception, and a stop returns the slave to idle with SDA released.
- R4: After the 8th bit of the address byte, and after each of the two write data bytes, the slave pulls SDA low from the SCL low phase through the whole 9th clock pulse.
- R5: Write data arrives high byte first and MSB first. In the 16-bit word, bit 15 is the active-high power-down control and bits 13:4 are the DAC code (bit 13 is the code MSB). Bits 14 and 3:0 have no effect on the outputs.
- R6: `dac_code` and `pwr_down` change only when the second write byte is received. A stop or repeated start after the first data byte leaves them unchanged.
- R7: A read (R/W bit = 1) returns the 16-bit holding word, high byte first and MSB first. Each bit is driven after an SCL falling edge.
- R8: When both read bytes have been transferred, the holding word becomes zero, so the next read returns 0x0000. The DAC outputs are unchanged by this.
- R9: The slave releases SDA in each master-acknowledge slot. A NACK after the first read byte ends the transfer: the slave drives nothing in any further clocks, and the holding word is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| dac_code | output | 10 | Converter code from the DAC register |
| pwr_down | output | 1 | Software power-down flag from the DAC register |

## Verification
The address logic is swept over all 128 seven-bit addresses. Only the four addresses that differ in their two don't-care bits may be acknowledged, which separates a mask of the wrong width or position from a correct one. Writes then step through a spread of DAC codes. Power-down and the unused bits alternate between writes, and the four address aliases are rotated, which exposes wrong field placement and byte order. Aborted writes (a stop after one byte, or a repeated start) show whether the DAC register waits for the second byte. Paired reads (full, then again), a read cut short by a NACK, and clocking after the NACK show the read-clear rule and that the slave releases the line.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WR_BITS,
    S_WR_ACK,
    S_RD_BITS,
    S_RD_ACK
  } bus_state_t;
endpackage

// File: rtl/dacbus_line_sync.sv
module dacbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw, cur, prv;
  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prv <= 2'b11;
    else     prv <= cur;
  end

  assign sda_s     = cur[0];
  assign scl_rise  = cur[1] & ~prv[1];
  assign scl_fall  = ~cur[1] & prv[1];
  assign start_det = cur[1] & prv[1] & prv[0] & ~cur[0];
  assign stop_det  = cur[1] & prv[1] & ~prv[0] & cur[0];
endmodule

// File: rtl/dacbus_slave_fsm.sv
module dacbus_slave_fsm
  import dacbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR     = 7'h0C,
  parameter int                ADDR_DC_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [WORD_W-1:0] word_in,
  output logic              sda_pull,
  output logic              hi_we,
  output logic              lo_we,
  output logic              clr,
  output logic [BYTE_W-1:0] byte_out
);
  localparam logic [ADDR_W-1:0] ADDR_MASK = 7'h7F << ADDR_DC_BITS;
  localparam logic [3:0]        LAST_BIT  = 4'(BYTE_W);

  bus_state_t        state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic [WORD_W-1:0] tx;
  logic              second, ack_ok;
  logic              byte_done, addr_hit;

  assign byte_done = scl_fall && (cnt == LAST_BIT);
  assign addr_hit  = ((sh[BYTE_W-1:1] ^ DEV_ADDR) & ADDR_MASK) == '0;
  assign hi_we     = (state == S_WR_BITS) && byte_done && !second;
  assign lo_we     = (state == S_WR_BITS) && byte_done && second;
  assign clr       = (state == S_RD_ACK) && scl_fall && second;
  assign byte_out  = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; sda_pull <= 1'b0; cnt <= '0; sh <= '0;
      tx <= '0; second <= 1'b0; ack_ok <= 1'b0;
    end else if (start_det) begin
      state <= S_ADDR; sda_pull <= 1'b0; cnt <= '0;
    end else if (stop_det) begin
      state <= S_IDLE; sda_pull <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_WR_BITS: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            if (state == S_WR_BITS) begin
              state <= S_WR_ACK; sda_pull <= 1'b1;
            end else if (addr_hit) begin
              state <= S_ADDR_ACK; sda_pull <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_ADDR_ACK: if (scl_fall) begin
          cnt <= '0; second <= 1'b0;
          if (sh[0]) begin
            state <= S_RD_BITS; tx <= word_in; sda_pull <= ~word_in[WORD_W-1];
          end else begin
            state <= S_WR_BITS; sda_pull <= 1'b0;
          end
        end
        S_WR_ACK: if (scl_fall) begin
          sda_pull <= 1'b0; cnt <= '0;
          if (!second) begin second <= 1'b1; state <= S_WR_BITS; end
          else state <= S_IDLE;
        end
        S_RD_BITS: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            tx <= tx << 1;
            if (cnt == LAST_BIT) begin
              sda_pull <= 1'b0; state <= S_RD_ACK;
            end else begin
              sda_pull <= ~tx[WORD_W-2];
            end
          end
        end
        S_RD_ACK: begin
          if (scl_rise) ack_ok <= ~sda_s;
          else if (scl_fall) begin
            if (ack_ok && !second) begin
              second <= 1'b1; cnt <= '0; state <= S_RD_BITS;
              sda_pull <= ~tx[WORD_W-1];
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_start_rearms_R3: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == S_ADDR) && !sda_pull && (cnt == 4'd0));
  assert_stop_idles_R3: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> (state == S_IDLE) && !sda_pull);
  assert_ack_held_R4: assert property (@(posedge clk) disable iff (rst)
    ((state == S_ADDR_ACK) || (state == S_WR_ACK)) && !scl_fall && !start_det && !stop_det
      |=> sda_pull);
  assert_master_slot_free_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD_ACK) |-> !sda_pull);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sda_pull);
endmodule

// File: rtl/dacbus_word_regs.sv
module dacbus_word_regs
  import dacbus_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int CODE_LSB = 4,
  parameter int PD_BIT   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic              clr,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down
);
  logic [WORD_W-1:0] next_word;
  assign next_word = {word[WORD_W-1:BYTE_W], byte_in};

  always_ff @(posedge clk) begin
    if (rst || clr)  word <= '0;
    else if (hi_we)  word[WORD_W-1:BYTE_W] <= byte_in;
    else if (lo_we)  word[BYTE_W-1:0] <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code <= '0; pwr_down <= 1'b0;
    end else if (lo_we) begin
      dac_code <= next_word[CODE_LSB +: CODE_W];
      pwr_down <= next_word[PD_BIT];
    end
  end

  assert_commit_only_R6: assert property (@(posedge clk) disable iff (rst)
    !lo_we |=> $stable(dac_code) && $stable(pwr_down));
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (word == '0));
endmodule

// File: rtl/dacbus_slave_top.sv
module dacbus_slave_top
  import dacbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR     = 7'h0C,
  parameter int                ADDR_DC_BITS = 2,
  parameter int                SYNC_STAGES  = 2,
  parameter int                CODE_W       = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic hi_we, lo_we, clr;
  logic [BYTE_W-1:0] byte_bus;
  logic [WORD_W-1:0] word;

  dacbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  dacbus_slave_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_DC_BITS(ADDR_DC_BITS)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .word_in(word), .sda_pull(sda_pull),
    .hi_we(hi_we), .lo_we(lo_we), .clr(clr), .byte_out(byte_bus)
  );

  dacbus_word_regs #(.CODE_W(CODE_W), .CODE_LSB(4), .PD_BIT(WORD_W - 1)) u_regs (
    .clk(clk), .rst(rst), .hi_we(hi_we), .lo_we(lo_we), .clr(clr), .byte_in(byte_bus),
    .word(word), .dac_code(dac_code), .pwr_down(pwr_down)
  );
endmodule

// File: tb/dacbus_slave_top_bench.sv
module dacbus_slave_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_bus;
  logic sda_pull, pwr_down;
  logic [9:0] dac_code;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_drv & ~sda_pull;

  dacbus_slave_top u_dacbus_slave_top (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus),
    .sda_pull(sda_pull), .dac_code(dac_code), .pwr_down(pwr_down)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    tick(Q); sda_drv = b;
    tick(Q); scl = 1'b1;
    tick(Q); s = sda_bus;
    tick(Q); scl = 1'b0;
  endtask

  task automatic do_start();
    sda_drv = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_drv = 1'b0; tick(Q); scl = 1'b0;
  endtask

  task automatic do_stop();
    tick(Q); sda_drv = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_drv = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
    clock_bit(1'b1, s);
    acked = (s == 1'b0);
  endtask

  task automatic recv_byte(input bit master_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); v[i] = s; end
    clock_bit(!master_ack, s);
  endtask

  task automatic write_word(input logic [7:0] ab, input logic [15:0] w);
    bit a0, a1, a2;
    do_start();
    send_byte(ab, a0); send_byte(w[15:8], a1); send_byte(w[7:0], a2);
    do_stop();
    check(a0, "R2 address ack", a0, 1);
    check(a1, "R4 first data ack", a1, 1);
    check(a2, "R4 second data ack", a2, 1);
  endtask

  task automatic read_word(input logic [7:0] ab, output logic [15:0] w);
    bit a0;
    logic [7:0] hi, lo;
    do_start();
    send_byte(ab, a0);
    recv_byte(1'b1, hi); recv_byte(1'b0, lo);
    do_stop();
    check(a0, "R2 read address ack", a0, 1);
    w = {hi, lo};
  endtask

  task automatic check_dac(input logic [15:0] w, input string req);
    check(dac_code == w[13:4], req, dac_code, w[13:4]);
    check(pwr_down == w[15], req, pwr_down, w[15]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] w, last, rd, w2;
    logic [7:0] hi;
    logic s;
    bit ack, a1, a2;
    int hits;
    tick(8); rst = 1'b0; tick(4);

    // R1: reset state
    check(dac_code == 10'd0, "R1 code", dac_code, 0);
    check(pwr_down == 1'b0, "R1 power-down", pwr_down, 0);
    check(sda_pull == 1'b0, "R1 pull", sda_pull, 0);
    read_word(8'h19, rd);
    check(rd == 16'h0, "R1 holding word", rd, 0);

    // R2: sweep every 7-bit address with a write byte
    hits = 0;
    for (int a = 0; a < 128; a++) begin
      do_start();
      send_byte({7'(a), 1'b0}, ack);
      do_stop();
      check(ack == ((a >> 2) == 3), "R2 address sweep", int'(ack), int'((a >> 2) == 3));
      if (ack) hits++;
    end
    check(hits == 4, "R2 alias count", hits, 4);
    check(dac_code == 10'd0, "R6 no write in sweep", dac_code, 0);

    // R5/R6: write sweep over codes, power-down and unused bits, rotating aliases
    last = '0;
    for (int i = 0; i < 28; i++) begin
      logic [9:0] code;
      code = 10'((i * 37 + 5) % 1024);
      if (i == 27) code = 10'h3FF;
      w = {1'(i % 2), 1'(i % 3 == 0), code, 4'(i)};
      write_word({5'b00011, 2'(i % 4), 1'b0}, w);
      check_dac(w, "R5 field placement");
      last = w;
    end

    // R6: stop after first data byte leaves DAC unchanged
    w2 = 16'h5A5A;
    do_start(); send_byte(8'h18, ack); send_byte(w2[15:8], a1); do_stop();
    check(ack && a1, "R4 partial acks", int'(ack && a1), 1);
    check_dac(last, "R6 stop abort");
    // R6/R3: repeated start after first data byte
    do_start(); send_byte(8'h1A, ack); send_byte(w2[15:8], a1);
    do_start(); send_byte(8'h1B, a2);
    check(a2, "R3 repeated start restarts address", a2, 1);
    recv_byte(1'b1, hi); recv_byte(1'b0, rd[7:0]); do_stop();
    check_dac(last, "R6 restart abort");
    check({hi, rd[7:0]} == {w2[15:8], last[7:0]}, "R7 partial word readback",
          {hi, rd[7:0]}, {w2[15:8], last[7:0]});

    // R7/R8: full read, then read-after-read is zero, DAC held
    w = 16'hB3C7;
    write_word(8'h18, w);
    check_dac(w, "R5 explicit word");
    read_word(8'h1F, rd);
    check(rd == w, "R7 read word", rd, w);
    read_word(8'h19, rd);
    check(rd == 16'h0, "R8 cleared after read", rd, 0);
    check_dac(w, "R8 DAC held after clear");

    // R9: NACK after first byte ends transfer, slave quiet, no clear
    w = 16'h6E21;
    write_word(8'h18, w);
    do_start(); send_byte(8'h19, ack); recv_byte(1'b0, hi);
    check(hi == w[15:8], "R7 first byte", hi, w[15:8]);
    rd = '0;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); rd[i] = s; end
    do_stop();
    check(rd[7:0] == 8'hFF, "R9 released after NACK", rd[7:0], 8'hFF);
    read_word(8'h19, rd);
    check(rd == w, "R9 no clear on NACK", rd, w);

    // R2: non-matching address gets no response to following clocks
    do_start(); send_byte(8'h30, ack);
    rd = '0;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); rd[i] = s; end
    do_stop();
    check(!ack && rd[7:0] == 8'hFF, "R2 foreign address quiet", rd[7:0], 8'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule